// File: doc/BRIEF.md
# Wake Input Conditioner

This block sits in an always-powered domain and conditions a small set of active-low wake and control pins. It folds them into a single control output. Each pin first passes through an input-buffer gate and a two-flop synchronizer. It then goes through a glitch filter that can be bypassed, which accepts a new level only after that level has been held for a set number of clocks.

Edge detectors watch the filtered level and record every falling and rising transition in sticky flags. They do this regardless of how the input is configured further down the path. After the edge tap, a per-input polarity select turns the filtered level into an "asserted" bit. That bit either passes straight to a status bit or is held in a set/reset latch, depending on a per-input latch enable.

The combined output is the OR of three terms: the status bits of the inputs enabled into it, an override input, and a power-up event input. A firmware-select bit can replace this whole hardware result with a firmware-written bit. A small register port gives read access to status, write-one-to-clear on the sticky bits, and writes to the configuration.

Top module: `wake_cond`

## Requirements
- R1: After reset, with all pins high, the status, falling-edge and rising-edge registers read 0, the input-buffer enable register reads all ones, the control register reads 0, and ctl_out is 0.
- R2: A change on a pin reaches the filtered level only after the synchronized value has differed for FILT_LEN consecutive clocks. The status bit changes FILT_LEN+3 rising edges after the pin changes. A pulse held for fewer than FILT_LEN clocks leaves no trace in the status or edge registers.
- R3: With the input's bit set in the bypass register (address 5), the synchronized pin feeds the downstream logic directly. The status bit changes 3 rising edges after the pin, and a one-clock pulse is recorded as edges.
- R4: Bit i of the falling-edge register (address 2) sets when the filtered level of pin i goes from high to low. Bit i of the rising-edge register (address 3) sets when it goes from low to high. Both are taken before polarity selection and are recorded even when the input is not enabled into the output and not latched.
- R5: Edge flags stay set until a 1 is written to their bit. Writing 0 to a bit leaves it unchanged.
- R6: With polarity bit i (address 6) at 0, input i is asserted when its filtered level is low. With the bit at 1, it is asserted when the level is high.
- R7: With latch-enable bit i (address 7) at 0, status bit i (address 1) follows the asserted value. With it at 1, status bit i sets on assertion and holds until a 1 is written to it at address 1 while the input is not asserted.
- R8: While the firmware select is 0, ctl_out is the OR of the status bits enabled in the output-enable register (address 8), ovrd_in and pwrup_evt.
- R9: Control register (address 0): bit 0 is the firmware output bit and bit 1 is the firmware select. While the select is 1, ctl_out equals the firmware bit whatever the inputs are.
- R10: With input-buffer enable bit i (address 4) at 0, pin i is treated as high regardless of its level.
- R11: Registers read back at the addresses above, zero-extended. Address 1 is read-only for values and uses writes only as clear strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on domain clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pin_n | input | NUM_IN | Active-low wake/control pins |
| ovrd_in | input | 1 | Override request into the combined output |
| pwrup_evt | input | 1 | Power-up event into the combined output |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | DW | Register write data, DW = max(NUM_IN, 2) |
| reg_rdata | output | DW | Register read data, combinational from reg_addr |
| ctl_out | output | 1 | Combined control output |

## Verification
The bench builds the block with three inputs and a filter length of 3. The third lane shows that lanes stay independent of each other. The short filter makes it cheap to place pulses of exactly FILT_LEN-1 and FILT_LEN clocks, which sit on either side of the acceptance boundary, and to count the exact rising edge at which a status bit moves in both filtered and bypassed mode. With these values, a randomized sequence of pin changes and configuration writes can visit the combinations of polarity, latching, buffer gating and output selection within a few thousand cycles.

// File: rtl/wake_cond_pkg.sv
package wake_cond_pkg;
  localparam int ADDR_W = 4;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL  = 4'd0,
    A_STAT  = 4'd1,
    A_FALL  = 4'd2,
    A_RISE  = 4'd3,
    A_BUFEN = 4'd4,
    A_BYP   = 4'd5,
    A_POL   = 4'd6,
    A_LATCH = 4'd7,
    A_OUTEN = 4'd8
  } reg_addr_e;
endpackage

// File: rtl/wake_cond_lane.sv
module wake_cond_lane #(
  parameter int FILT_LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  input  logic buf_en,
  input  logic bypass,
  input  logic pol_inv,
  input  logic latch_en,
  input  logic clr_stat,
  input  logic clr_fall,
  input  logic clr_rise,
  output logic filt_o,
  output logic asrt_o,
  output logic stat_o,
  output logic fall_o,
  output logic rise_o
);
  localparam int CW = (FILT_LEN > 2) ? $clog2(FILT_LEN) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(FILT_LEN - 1);

  logic gated;
  logic sync1_q, sync2_q;
  logic filt_q, filt_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic prev_q;
  logic fall_q, fall_d, rise_q, rise_d;
  logic stat_q, stat_d;

  // buffer gate: a disabled buffer reads as the released (high) level
  assign gated = buf_en ? pin_n : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b1;
      sync2_q <= 1'b1;
    end else begin
      sync1_q <= gated;
      sync2_q <= sync1_q;
    end
  end

  // stability filter: commit only after FILT_LEN consecutive differing clocks
  always_comb begin
    filt_d = filt_q;
    cnt_d  = '0;
    if (sync2_q != filt_q) begin
      if (cnt_q == CNT_LAST) filt_d = sync2_q;
      else                   cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      filt_q <= 1'b1;
      cnt_q  <= '0;
    end else begin
      filt_q <= filt_d;
      cnt_q  <= cnt_d;
    end
  end

  assign filt_o = bypass ? sync2_q : filt_q;

  // edge taps sit before polarity selection
  assign asrt_o = pol_inv ? filt_o : ~filt_o;

  always_comb begin
    fall_d = (fall_q & ~clr_fall) | (prev_q & ~filt_o);
    rise_d = (rise_q & ~clr_rise) | (~prev_q & filt_o);
    stat_d = latch_en ? ((stat_q & ~clr_stat) | asrt_o) : asrt_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b1;
      fall_q <= 1'b0;
      rise_q <= 1'b0;
      stat_q <= 1'b0;
    end else begin
      prev_q <= filt_o;
      fall_q <= fall_d;
      rise_q <= rise_d;
      stat_q <= stat_d;
    end
  end

  assign stat_o = stat_q;
  assign fall_o = fall_q;
  assign rise_o = rise_q;
endmodule

// File: rtl/wake_cond_regs.sv
module wake_cond_regs
  import wake_cond_pkg::*;
#(
  parameter int NUM_IN = 2,
  parameter int DW     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     wdata,
  output logic [DW-1:0]     rdata,
  input  logic [NUM_IN-1:0] stat,
  input  logic [NUM_IN-1:0] fall,
  input  logic [NUM_IN-1:0] rise,
  output logic [NUM_IN-1:0] buf_en,
  output logic [NUM_IN-1:0] bypass,
  output logic [NUM_IN-1:0] pol_inv,
  output logic [NUM_IN-1:0] latch_en,
  output logic [NUM_IN-1:0] out_en,
  output logic              fw_sel,
  output logic              fw_bit,
  output logic [NUM_IN-1:0] clr_stat,
  output logic [NUM_IN-1:0] clr_fall,
  output logic [NUM_IN-1:0] clr_rise
);
  logic [NUM_IN-1:0] buf_q, buf_d, byp_q, byp_d, pol_q, pol_d;
  logic [NUM_IN-1:0] lat_q, lat_d, oen_q, oen_d;
  logic              fsel_q, fsel_d, fbit_q, fbit_d;
  logic [NUM_IN-1:0] wvec;

  assign wvec = wdata[NUM_IN-1:0];

  always_comb begin
    buf_d  = buf_q;
    byp_d  = byp_q;
    pol_d  = pol_q;
    lat_d  = lat_q;
    oen_d  = oen_q;
    fsel_d = fsel_q;
    fbit_d = fbit_q;
    if (wr_en) begin
      case (addr)
        A_CTRL:  begin fbit_d = wdata[0]; fsel_d = wdata[1]; end
        A_BUFEN: buf_d = wvec;
        A_BYP:   byp_d = wvec;
        A_POL:   pol_d = wvec;
        A_LATCH: lat_d = wvec;
        A_OUTEN: oen_d = wvec;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q  <= '1;
      byp_q  <= '0;
      pol_q  <= '0;
      lat_q  <= '0;
      oen_q  <= '0;
      fsel_q <= 1'b0;
      fbit_q <= 1'b0;
    end else begin
      buf_q  <= buf_d;
      byp_q  <= byp_d;
      pol_q  <= pol_d;
      lat_q  <= lat_d;
      oen_q  <= oen_d;
      fsel_q <= fsel_d;
      fbit_q <= fbit_d;
    end
  end

  // write-one-to-clear strobes, valid only in the write cycle
  assign clr_stat = (wr_en && addr == A_STAT) ? wvec : '0;
  assign clr_fall = (wr_en && addr == A_FALL) ? wvec : '0;
  assign clr_rise = (wr_en && addr == A_RISE) ? wvec : '0;

  always_comb begin
    case (addr)
      A_CTRL:  rdata = DW'({fsel_q, fbit_q});
      A_STAT:  rdata = DW'(stat);
      A_FALL:  rdata = DW'(fall);
      A_RISE:  rdata = DW'(rise);
      A_BUFEN: rdata = DW'(buf_q);
      A_BYP:   rdata = DW'(byp_q);
      A_POL:   rdata = DW'(pol_q);
      A_LATCH: rdata = DW'(lat_q);
      A_OUTEN: rdata = DW'(oen_q);
      default: rdata = '0;
    endcase
  end

  assign buf_en   = buf_q;
  assign bypass   = byp_q;
  assign pol_inv  = pol_q;
  assign latch_en = lat_q;
  assign out_en   = oen_q;
  assign fw_sel   = fsel_q;
  assign fw_bit   = fbit_q;
endmodule

// File: rtl/wake_cond.sv
module wake_cond
  import wake_cond_pkg::*;
#(
  parameter  int NUM_IN   = 2,
  parameter  int FILT_LEN = 4,
  localparam int DW       = (NUM_IN > 2) ? NUM_IN : 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_IN-1:0] pin_n,
  input  logic              ovrd_in,
  input  logic              pwrup_evt,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  output logic              ctl_out
);
  logic rst_meta_q, rst_q_n;
  logic [NUM_IN-1:0] filt_v, asrt_v, stat_v, fall_v, rise_v;
  logic [NUM_IN-1:0] buf_en_v, bypass_v, pol_v, latch_en_v, out_en_v;
  logic [NUM_IN-1:0] clr_stat_v, clr_fall_v, clr_rise_v;
  logic fw_sel, fw_bit, hw_out;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_q_n    <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_q_n    <= rst_meta_q;
    end
  end

  wake_cond_regs #(.NUM_IN(NUM_IN), .DW(DW)) u_regs (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .wr_en    (reg_wr),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .rdata    (reg_rdata),
    .stat     (stat_v),
    .fall     (fall_v),
    .rise     (rise_v),
    .buf_en   (buf_en_v),
    .bypass   (bypass_v),
    .pol_inv  (pol_v),
    .latch_en (latch_en_v),
    .out_en   (out_en_v),
    .fw_sel   (fw_sel),
    .fw_bit   (fw_bit),
    .clr_stat (clr_stat_v),
    .clr_fall (clr_fall_v),
    .clr_rise (clr_rise_v)
  );

  for (genvar i = 0; i < NUM_IN; i++) begin : g_lane
    wake_cond_lane #(.FILT_LEN(FILT_LEN)) u_lane (
      .clk      (clk),
      .rst_n    (rst_q_n),
      .pin_n    (pin_n[i]),
      .buf_en   (buf_en_v[i]),
      .bypass   (bypass_v[i]),
      .pol_inv  (pol_v[i]),
      .latch_en (latch_en_v[i]),
      .clr_stat (clr_stat_v[i]),
      .clr_fall (clr_fall_v[i]),
      .clr_rise (clr_rise_v[i]),
      .filt_o   (filt_v[i]),
      .asrt_o   (asrt_v[i]),
      .stat_o   (stat_v[i]),
      .fall_o   (fall_v[i]),
      .rise_o   (rise_v[i])
    );
  end

  assign hw_out  = (|(stat_v & out_en_v)) | ovrd_in | pwrup_evt;
  assign ctl_out = fw_sel ? fw_bit : hw_out;
endmodule

// File: rtl/wake_cond_chk.sv
module wake_cond_chk #(
  parameter int NUM_IN = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fw_sel,
  input logic              fw_bit,
  input logic              ovrd_in,
  input logic              pwrup_evt,
  input logic              ctl_out,
  input logic [NUM_IN-1:0] filt,
  input logic [NUM_IN-1:0] asrt,
  input logic [NUM_IN-1:0] stat,
  input logic [NUM_IN-1:0] fall,
  input logic [NUM_IN-1:0] rise,
  input logic [NUM_IN-1:0] latch_en,
  input logic [NUM_IN-1:0] clr_stat,
  input logic [NUM_IN-1:0] clr_fall,
  input logic [NUM_IN-1:0] clr_rise
);
  p_fw_out_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fw_sel |-> (ctl_out == fw_bit));

  p_force_out_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!fw_sel && (ovrd_in || pwrup_evt)) |-> ctl_out);

  for (genvar i = 0; i < NUM_IN; i++) begin : g_chk
    p_fall_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(filt[i]) |=> fall[i]);

    p_rise_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(filt[i]) |=> rise[i]);

    p_fall_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (fall[i] && !clr_fall[i]) |=> fall[i]);

    p_rise_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rise[i] && !clr_rise[i]) |=> rise[i]);

    p_latch_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (latch_en[i] && stat[i] && !clr_stat[i]) |=> stat[i]);

    p_live_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !latch_en[i] |=> (stat[i] == $past(asrt[i])));
  end
endmodule

bind wake_cond wake_cond_chk #(.NUM_IN(NUM_IN)) u_chk (
  .clk       (clk),
  .rst_n     (rst_q_n),
  .fw_sel    (fw_sel),
  .fw_bit    (fw_bit),
  .ovrd_in   (ovrd_in),
  .pwrup_evt (pwrup_evt),
  .ctl_out   (ctl_out),
  .filt      (filt_v),
  .asrt      (asrt_v),
  .stat      (stat_v),
  .fall      (fall_v),
  .rise      (rise_v),
  .latch_en  (latch_en_v),
  .clr_stat  (clr_stat_v),
  .clr_fall  (clr_fall_v),
  .clr_rise  (clr_rise_v)
);

// File: tb/wake_cond_test.sv
module wake_cond_test;
  localparam int N  = 3;
  localparam int L  = 3;
  localparam int DW = 3;

  localparam logic [3:0] AD_CTRL = 4'd0, AD_STAT = 4'd1, AD_FALL = 4'd2,
    AD_RISE = 4'd3, AD_BUF = 4'd4, AD_BYP = 4'd5, AD_POL = 4'd6,
    AD_LAT = 4'd7, AD_OEN = 4'd8;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n;
  logic [N-1:0]  pin_n;
  logic          ovrd_in, pwrup_evt, reg_wr;
  logic [3:0]    reg_addr;
  logic [DW-1:0] reg_wdata, reg_rdata;
  logic          ctl_out;

  wake_cond #(.NUM_IN(N), .FILT_LEN(L)) uut (
    .clk(clk), .rst_n(rst_n), .pin_n(pin_n), .ovrd_in(ovrd_in),
    .pwrup_evt(pwrup_evt), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ctl_out(ctl_out));

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // requirement-level model, valid once inputs have been steady long enough
  logic [N-1:0] m_pin, m_buf, m_byp, m_pol, m_lat, m_oen, m_filt;
  logic [N-1:0] m_stat, m_fall, m_rise;
  logic         m_fsel, m_fbit;

  task automatic chk(string tag, logic [DW-1:0] got, logic [DW-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", tag, got, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(logic [3:0] a, logic [DW-1:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [DW-1:0] v);
    reg_addr = a;
    #1;
    v = reg_rdata;
  endtask

  function automatic logic [N-1:0] eff_level();
    return m_pin | ~m_buf;
  endfunction

  task automatic m_step(logic [N-1:0] clr_s);
    logic [N-1:0] eff, a;
    eff    = eff_level();
    m_fall = m_fall | (m_filt & ~eff);
    m_rise = m_rise | (~m_filt & eff);
    m_filt = eff;
    a      = eff ^ ~m_pol;
    m_stat = a | (m_stat & m_lat & ~clr_s);
  endtask

  function automatic logic exp_out();
    if (m_fsel) return m_fbit;
    return (|(m_stat & m_oen)) | ovrd_in | pwrup_evt;
  endfunction

  task automatic m_reset();
    m_pin = '1; m_buf = '1; m_byp = '0; m_pol = '0; m_lat = '0; m_oen = '0;
    m_filt = '1; m_stat = '0; m_fall = '0; m_rise = '0;
    m_fsel = 1'b0; m_fbit = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; pin_n = '1; ovrd_in = 1'b0; pwrup_evt = 1'b0;
    reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    m_reset();
    tick(2);
    rst_n = 1'b1;
    tick(4);
  endtask

  task automatic check_all(string tag);
    logic [DW-1:0] v;
    rd(AD_STAT, v); chk({tag, " status R6 R7"}, v, DW'(m_stat));
    rd(AD_FALL, v); chk({tag, " fall R4 R5"}, v, DW'(m_fall));
    rd(AD_RISE, v); chk({tag, " rise R4 R5"}, v, DW'(m_rise));
    chk({tag, " ctl_out R8 R9"}, DW'(ctl_out), DW'(exp_out()));
  endtask

  task automatic settle(string tag);
    tick(L + 6);
    m_step('0);
    check_all(tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] v;
    void'($urandom(32'd5171));
    do_reset();

    // R1 reset state
    check_all("R1 reset");
    rd(AD_BUF, v);  chk("R1 R11 buffer enable reset", v, 3'b111);
    rd(AD_CTRL, v); chk("R1 R11 control reset", v, 3'b000);

    // R2 exact filter latency
    pin_n[0] = 1'b0; m_pin[0] = 1'b0;
    tick(L + 2);
    rd(AD_STAT, v); chk("R2 status before FILT_LEN+3 edges", v, 3'b000);
    tick(1);
    rd(AD_STAT, v); chk("R2 status at FILT_LEN+3 edges", v, 3'b001);
    settle("R2 R4 unlatched edge");

    // R2 pulse one clock short of FILT_LEN is dropped
    pin_n[1] = 1'b0;
    tick(L - 1);
    pin_n[1] = 1'b1;
    tick(L + 6);
    check_all("R2 short pulse");
    // pulse of exactly FILT_LEN passes
    pin_n[1] = 1'b0;
    tick(L);
    pin_n[1] = 1'b1;
    tick(L + 6);
    m_fall[1] = 1'b1; m_rise[1] = 1'b1;
    check_all("R2 full pulse");

    // R3 bypass latency and one-clock pulse
    wr(AD_BYP, 3'b100); m_byp = 3'b100;
    pin_n[2] = 1'b0; m_pin[2] = 1'b0;
    tick(2);
    rd(AD_STAT, v); chk("R3 bypass status before 3 edges", v, 3'b001);
    tick(1);
    rd(AD_STAT, v); chk("R3 bypass status at 3 edges", v, 3'b101);
    pin_n[2] = 1'b1;
    tick(1);
    pin_n[2] = 1'b0;
    tick(6);
    m_step('0);
    m_rise[2] = 1'b1;
    check_all("R3 bypass one-clock pulse");

    // R5 write 0 keeps, write 1 clears
    wr(AD_FALL, 3'b000); tick(1);
    check_all("R5 zero write");
    wr(AD_FALL, 3'b101); m_fall = m_fall & ~3'b101; tick(1);
    check_all("R5 clear fall");

    // R6 polarity, R4 edges independent of polarity
    wr(AD_POL, 3'b001); m_pol = 3'b001;
    settle("R6 polarity inverted low pin");
    pin_n[0] = 1'b1; m_pin[0] = 1'b1;
    settle("R6 R4 polarity inverted high pin");

    // R7 latching
    wr(AD_LAT, 3'b111); m_lat = 3'b111;
    settle("R7 latch on");
    pin_n[1] = 1'b0; m_pin[1] = 1'b0;
    settle("R7 assert");
    pin_n[1] = 1'b1; m_pin[1] = 1'b1;
    settle("R7 held after release");
    wr(AD_STAT, 3'b010); m_step(3'b010); tick(1);
    check_all("R7 clear released");
    wr(AD_STAT, 3'b001); m_step(3'b001); tick(1);
    check_all("R7 clear while asserted");

    // R8 combine
    wr(AD_OEN, 3'b010); m_oen = 3'b010; tick(1);
    chk("R8 disabled inputs give 0", DW'(ctl_out), 3'd0);
    ovrd_in = 1'b1; #1;
    chk("R8 override", DW'(ctl_out), 3'd1);
    ovrd_in = 1'b0; pwrup_evt = 1'b1; #1;
    chk("R8 power-up event", DW'(ctl_out), 3'd1);
    pwrup_evt = 1'b0;
    wr(AD_OEN, 3'b100); m_oen = 3'b100; tick(1);
    chk("R8 enabled asserted input", DW'(ctl_out), 3'd1);

    // R9 firmware select
    wr(AD_CTRL, 3'b010); m_fsel = 1'b1; m_fbit = 1'b0; ovrd_in = 1'b1; tick(1);
    chk("R9 firmware bit 0", DW'(ctl_out), 3'd0);
    wr(AD_CTRL, 3'b011); m_fbit = 1'b1; tick(1);
    chk("R9 firmware bit 1", DW'(ctl_out), 3'd1);
    rd(AD_CTRL, v); chk("R9 R11 control readback", v, 3'b011);
    wr(AD_CTRL, 3'b000); m_fsel = 1'b0; m_fbit = 1'b0; ovrd_in = 1'b0;

    // R10 buffer disable reads as high
    wr(AD_BUF, 3'b011); m_buf = 3'b011;
    settle("R10 buffer off");
    wr(AD_STAT, 3'b100); m_step(3'b100); tick(1);
    check_all("R10 buffer off cleared");
    rd(AD_LAT, v); chk("R11 latch enable readback", v, 3'b111);

    // randomized phase
    do_reset();
    for (int it = 0; it < 300; it++) begin
      int op;
      logic [DW-1:0] d;
      op = $urandom_range(0, 9);
      d  = DW'($urandom);
      ovrd_in   = ($urandom_range(0, 7) == 0);
      pwrup_evt = ($urandom_range(0, 7) == 0);
      case (op)
        0, 1, 2: begin pin_n = d; m_pin = d; end
        3: begin
          if ($urandom_range(0, 3) != 0) d = '1;
          wr(AD_BUF, d); m_buf = d;
        end
        4: begin wr(AD_BYP, d); m_byp = d; end
        5: begin wr(AD_POL, d); m_pol = d; end
        6: begin wr(AD_LAT, d); m_lat = d; end
        7: begin wr(AD_OEN, d); m_oen = d; end
        8: begin
          d[1] = ($urandom_range(0, 3) == 0);
          wr(AD_CTRL, d); m_fbit = d[0]; m_fsel = d[1];
        end
        default: begin
          case ($urandom_range(0, 2))
            0: begin wr(AD_STAT, d); m_step(d); end
            1: begin wr(AD_FALL, d); m_fall = m_fall & ~d; end
            default: begin wr(AD_RISE, d); m_rise = m_rise & ~d; end
          endcase
        end
      endcase
      settle("random");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule